// File: doc/BRIEF.md
# Linear-Hash Way Predictor

This block guesses which way of an 8-way, 64-set first-level data cache holds a load's line, using only the linear address, before translation finishes. Each cache entry carries a short 8-bit micro-tag, a fold of the upper linear address bits, next to its physical tag and a valid bit. A lookup selects the set from the linear address, folds the address into a micro-tag and returns the single way whose stored micro-tag matches. If no way matches, it returns a predicted miss.

When the translated address arrives, a validation request compares the physical tag against the predicted way only. The block returns a one-hot outcome class. Any outcome other than a confirmed hit raises a fill request. The returning fill updates the micro-tags, physical tags and valid bits of the set. A set never holds two valid entries with the same micro-tag or two copies of the same physical line. Data storage, translation, the next cache level and the replacement policy are outside the block. The replacement policy supplies a victim way on the fill port.

Lookups, validations and fills use separate ports and may all be active in the same cycle. Lookup and validation results are registered and appear one cycle after the request. A fill updates the arrays at the clock edge. A lookup or validation presented in the same cycle as a fill sees the state before that fill.

Top module: `linear_way_predictor`

## Requirements
- R1: The set is linear address bits 11:6. A fill in one set never changes a lookup in another set, even when the micro-tag is equal.
- R2: The micro-tag bit i is address bit 12+i XOR address bit 20+i, for i = 0..7. One cycle after `lk_valid`, `pred_valid` is 1. `pred_hit` is 1 exactly when a valid entry of the set holds that micro-tag, and `pred_way` then names that entry.
- R3: Whatever fills have occurred, a set holds at most one valid entry per micro-tag value. A lookup therefore names at most one way.
- R4: One cycle after `vl_valid`, `cls_valid` is 1 and `cls_onehot` has exactly one bit set:
  - bit 0: micro-tag hit, and the predicted way's physical tag matches.
  - bit 1: micro-tag hit, and that way's physical tag differs.
  - bit 2: no micro-tag hit, but the line is present in the set.
  - bit 3: no micro-tag hit and the line is absent.
- R5: `fill_req` is 1 together with `cls_valid` for classes bit 1, bit 2 and bit 3, and 0 for bit 0.
- R6: A fill whose line is absent from the set, and whose micro-tag no way holds, writes the line into way `fl_victim` and marks it valid.
- R7: A fill whose line is absent but whose micro-tag is held by a way overwrites that way's physical tag. `fl_victim` is ignored, even when the set has an empty way.
- R8: A fill whose line is present, with no other way holding its micro-tag, rewrites only that entry's micro-tag. `fl_victim` is ignored.
- R9: A fill whose line is present in one way while a different way holds its micro-tag rewrites the micro-tag of the line's way and invalidates the other way.
- R10: Synchronous active-low reset clears every valid bit and the output strobes. Every lookup afterwards predicts a miss until a fill.
- R11: A lookup or validation in the same cycle as a fill is answered from the state before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_laddr | input | 22 | Lookup linear address, bits 27:6 |
| pred_valid | output | 1 | Prediction strobe |
| pred_hit | output | 1 | A way is predicted |
| pred_way | output | 3 | Predicted way |
| vl_valid | input | 1 | Validation request |
| vl_laddr | input | 22 | Validation linear address, bits 27:6 |
| vl_ptag | input | 24 | Translated physical tag |
| cls_valid | output | 1 | Outcome strobe |
| cls_onehot | output | 4 | One-hot outcome class |
| fill_req | output | 1 | Line must be fetched from the next level |
| fl_valid | input | 1 | Fill response |
| fl_laddr | input | 22 | Fill linear address, bits 27:6 |
| fl_ptag | input | 24 | Fill physical tag |
| fl_victim | input | 3 | Way chosen by the replacement policy |

## Verification
The hardest state to reach is R9. One line must already sit in the set under one micro-tag, a different line must hold a second micro-tag, and a fill must bring the first line back under the second micro-tag. Random addresses almost never produce this.

The stimulus confines random addresses to four sets and to a few micro-tag patterns. The folded value of several distinct addresses is identical, so aliases occur. Physical tags come from a pool of six. With these limits the R7, R8 and R9 cases recur constantly. Directed sequences also build each of these cases deliberately, and the stimulus places a fill and a probe in the same cycle.

// File: rtl/wp_pkg.sv
// Shared types for the linear-hash way predictor.
// Assumes the outcome classes map onto one-hot bit positions by their value.
package wp_pkg;
    localparam int WP_CLS_W = 4;

    typedef enum logic [1:0] {
        WP_TRUE_HIT     = 2'd0,
        WP_FALSE_HIT    = 2'd1,
        WP_MISS_PRESENT = 2'd2,
        WP_TRUE_MISS    = 2'd3
    } wp_outcome_e;
endpackage

// File: rtl/wp_hash.sv
// Splits a line address into its set index and folds the bits above it into a micro-tag.
// Assumes the address carries exactly 2*UT_W bits above the index.
module wp_hash #(
    parameter int LINE_OFF = 6,
    parameter int IDX_W    = 6,
    parameter int UT_W     = 8,
    localparam int LA_W    = LINE_OFF + IDX_W + 2 * UT_W
) (
    input  logic [LA_W-1:LINE_OFF] laddr,
    output logic [IDX_W-1:0]       set_idx,
    output logic [UT_W-1:0]        utag
);
    localparam int HB = LINE_OFF + IDX_W;

    // set index is taken directly above the line offset
    assign set_idx = laddr[HB-1:LINE_OFF];

    // each micro-tag bit folds one low and one high upper-address bit
    for (genvar i = 0; i < UT_W; i++) begin : g_fold
        assign utag[i] = laddr[HB + i] ^ laddr[HB + UT_W + i];
    end
endmodule

// File: rtl/wp_ut_match.sv
// Compares a micro-tag against every valid way of one set and encodes the hit.
// Assumes at most one way matches; with several, the highest index wins.
module wp_ut_match #(
    parameter int WAYS  = 8,
    parameter int UT_W  = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]      row_vld,
    input  logic [WAYS*UT_W-1:0] row_ut,
    input  logic [UT_W-1:0]      key_ut,
    output logic [WAYS-1:0]      hit,
    output logic                 any,
    output logic [WAY_W-1:0]     way
);
    // per-way equality gated by valid
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit[w] = row_vld[w] && (row_ut[w*UT_W +: UT_W] == key_ut);
    end

    assign any = |hit;

    // binary encode of the matching way
    always_comb begin
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/wp_set_match.sv
// Full set compare: micro-tag match plus physical tag match over all ways.
// Also reports whether the micro-tag-predicted way holds the physical tag.
module wp_set_match #(
    parameter int WAYS  = 8,
    parameter int UT_W  = 8,
    parameter int PT_W  = 24,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]      row_vld,
    input  logic [WAYS*UT_W-1:0] row_ut,
    input  logic [WAYS*PT_W-1:0] row_pt,
    input  logic [UT_W-1:0]      key_ut,
    input  logic [PT_W-1:0]      key_pt,
    output logic [WAYS-1:0]      ut_hit,
    output logic                 ut_any,
    output logic [WAY_W-1:0]     ut_way,
    output logic [WAYS-1:0]      pt_hit,
    output logic                 pt_any,
    output logic [WAY_W-1:0]     pt_way,
    output logic                 pred_ok
);
    wp_ut_match #(.WAYS(WAYS), .UT_W(UT_W)) i_ut (
        .row_vld (row_vld),
        .row_ut  (row_ut),
        .key_ut  (key_ut),
        .hit     (ut_hit),
        .any     (ut_any),
        .way     (ut_way)
    );

    // physical tag equality per valid way
    for (genvar w = 0; w < WAYS; w++) begin : g_pt
        assign pt_hit[w] = row_vld[w] && (row_pt[w*PT_W +: PT_W] == key_pt);
    end

    assign pt_any = |pt_hit;

    // binary encode of the way holding the physical line
    always_comb begin
        pt_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (pt_hit[w]) pt_way = WAY_W'(w);
        end
    end

    // validation looks only at the predicted way
    assign pred_ok = ut_any && pt_hit[ut_way];
endmodule

// File: rtl/wp_store.sv
// Micro-tag, physical tag and valid arrays with three combinational read ports
// and one write port that can also invalidate a second way of the same set.
// Assumes the writer never invalidates the way it writes.
module wp_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int UT_W  = 8,
    parameter int PT_W  = 24,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     a_idx,
    output logic [WAYS-1:0]      a_vld,
    output logic [WAYS*UT_W-1:0] a_ut,
    input  logic [IDX_W-1:0]     b_idx,
    output logic [WAYS-1:0]      b_vld,
    output logic [WAYS*UT_W-1:0] b_ut,
    output logic [WAYS*PT_W-1:0] b_pt,
    input  logic [IDX_W-1:0]     c_idx,
    output logic [WAYS-1:0]      c_vld,
    output logic [WAYS*UT_W-1:0] c_ut,
    output logic [WAYS*PT_W-1:0] c_pt,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WAY_W-1:0]     wr_way,
    input  logic [UT_W-1:0]      wr_ut,
    input  logic [PT_W-1:0]      wr_pt,
    input  logic                 inv_en,
    input  logic [WAY_W-1:0]     inv_way
);
    logic [WAYS-1:0] vld_mem [SETS];
    logic [UT_W-1:0] ut_mem  [SETS][WAYS];
    logic [PT_W-1:0] pt_mem  [SETS][WAYS];

    // valid bits: cleared by reset, set by a write, cleared by an invalidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
        end else begin
            if (wr_en)  vld_mem[wr_idx][wr_way]  <= 1'b1;
            if (inv_en) vld_mem[wr_idx][inv_way] <= 1'b0;
        end
    end

    // tag payload: written without reset, qualified by valid
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ut_mem[wr_idx][wr_way] <= wr_ut;
            pt_mem[wr_idx][wr_way] <= wr_pt;
        end
    end

    assign a_vld = vld_mem[a_idx];
    assign b_vld = vld_mem[b_idx];
    assign c_vld = vld_mem[c_idx];

    // flatten the selected rows for the comparators
    for (genvar w = 0; w < WAYS; w++) begin : g_row
        assign a_ut[w*UT_W +: UT_W] = ut_mem[a_idx][w];
        assign b_ut[w*UT_W +: UT_W] = ut_mem[b_idx][w];
        assign b_pt[w*PT_W +: PT_W] = pt_mem[b_idx][w];
        assign c_ut[w*UT_W +: UT_W] = ut_mem[c_idx][w];
        assign c_pt[w*PT_W +: PT_W] = pt_mem[c_idx][w];
    end

    // R9
    inv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |-> (wr_en && inv_way != wr_way));
endmodule

// File: rtl/linear_way_predictor.sv
// Way predictor for a set-associative data cache indexed by linear address.
// Predicts a way from a folded micro-tag, classifies the prediction once the
// physical tag is known, and applies fill responses so that micro-tags and
// physical lines stay unique within each set. The victim way comes from outside.
module linear_way_predictor #(
    parameter int LINE_OFF = 6,
    parameter int SETS     = 64,
    parameter int WAYS     = 8,
    parameter int UT_W     = 8,
    parameter int PT_W     = 24,
    localparam int IDX_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int LA_W    = LINE_OFF + IDX_W + 2 * UT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [LA_W-1:LINE_OFF]  lk_laddr,
    output logic                    pred_valid,
    output logic                    pred_hit,
    output logic [WAY_W-1:0]        pred_way,
    input  logic                    vl_valid,
    input  logic [LA_W-1:LINE_OFF]  vl_laddr,
    input  logic [PT_W-1:0]         vl_ptag,
    output logic                    cls_valid,
    output logic [3:0]              cls_onehot,
    output logic                    fill_req,
    input  logic                    fl_valid,
    input  logic [LA_W-1:LINE_OFF]  fl_laddr,
    input  logic [PT_W-1:0]         fl_ptag,
    input  logic [WAY_W-1:0]        fl_victim
);
    import wp_pkg::*;

    logic [IDX_W-1:0]     lk_idx, vl_idx, fl_idx;
    logic [UT_W-1:0]      lk_ut, vl_ut, fl_ut;
    logic [WAYS-1:0]      a_vld, b_vld, c_vld;
    logic [WAYS*UT_W-1:0] a_ut, b_ut, c_ut;
    logic [WAYS*PT_W-1:0] b_pt, c_pt;

    logic [WAYS-1:0]  lk_hit;
    logic             lk_any;
    logic [WAY_W-1:0] lk_way;

    logic [WAYS-1:0]  v_ut_hit, v_pt_hit;
    logic             v_ut_any, v_pt_any, v_ok;
    logic [WAY_W-1:0] v_ut_way, v_pt_way;

    logic [WAYS-1:0]  f_ut_hit, f_pt_hit;
    logic             f_ut_any, f_pt_any, f_ok;
    logic [WAY_W-1:0] f_ut_way, f_pt_way;

    logic             wr_en, inv_en;
    logic [WAY_W-1:0] wr_way, inv_way;
    wp_outcome_e      outcome;

    wp_hash #(.LINE_OFF(LINE_OFF), .IDX_W(IDX_W), .UT_W(UT_W)) i_lk_hash (
        .laddr(lk_laddr), .set_idx(lk_idx), .utag(lk_ut));
    wp_hash #(.LINE_OFF(LINE_OFF), .IDX_W(IDX_W), .UT_W(UT_W)) i_vl_hash (
        .laddr(vl_laddr), .set_idx(vl_idx), .utag(vl_ut));
    wp_hash #(.LINE_OFF(LINE_OFF), .IDX_W(IDX_W), .UT_W(UT_W)) i_fl_hash (
        .laddr(fl_laddr), .set_idx(fl_idx), .utag(fl_ut));

    wp_store #(.SETS(SETS), .WAYS(WAYS), .UT_W(UT_W), .PT_W(PT_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (lk_idx),
        .a_vld   (a_vld),
        .a_ut    (a_ut),
        .b_idx   (vl_idx),
        .b_vld   (b_vld),
        .b_ut    (b_ut),
        .b_pt    (b_pt),
        .c_idx   (fl_idx),
        .c_vld   (c_vld),
        .c_ut    (c_ut),
        .c_pt    (c_pt),
        .wr_en   (wr_en),
        .wr_idx  (fl_idx),
        .wr_way  (wr_way),
        .wr_ut   (fl_ut),
        .wr_pt   (fl_ptag),
        .inv_en  (inv_en),
        .inv_way (inv_way)
    );

    wp_ut_match #(.WAYS(WAYS), .UT_W(UT_W)) i_lk_match (
        .row_vld(a_vld), .row_ut(a_ut), .key_ut(lk_ut),
        .hit(lk_hit), .any(lk_any), .way(lk_way));

    wp_set_match #(.WAYS(WAYS), .UT_W(UT_W), .PT_W(PT_W)) i_vl_match (
        .row_vld(b_vld), .row_ut(b_ut), .row_pt(b_pt),
        .key_ut(vl_ut), .key_pt(vl_ptag),
        .ut_hit(v_ut_hit), .ut_any(v_ut_any), .ut_way(v_ut_way),
        .pt_hit(v_pt_hit), .pt_any(v_pt_any), .pt_way(v_pt_way),
        .pred_ok(v_ok));

    wp_set_match #(.WAYS(WAYS), .UT_W(UT_W), .PT_W(PT_W)) i_fl_match (
        .row_vld(c_vld), .row_ut(c_ut), .row_pt(c_pt),
        .key_ut(fl_ut), .key_pt(fl_ptag),
        .ut_hit(f_ut_hit), .ut_any(f_ut_any), .ut_way(f_ut_way),
        .pt_hit(f_pt_hit), .pt_any(f_pt_any), .pt_way(f_pt_way),
        .pred_ok(f_ok));

    // fill action: keep the present line, else reuse the same-hash way, else the victim
    always_comb begin
        wr_en   = fl_valid;
        wr_way  = fl_victim;
        inv_en  = 1'b0;
        inv_way = f_ut_way;
        if (f_pt_any) begin
            wr_way = f_pt_way;
            inv_en = fl_valid && f_ut_any && !f_ok;
        end else if (f_ut_any) begin
            wr_way = f_ut_way;
        end
    end

    // classify the validated prediction
    always_comb begin
        if (v_ut_any) outcome = v_ok ? WP_TRUE_HIT : WP_FALSE_HIT;
        else          outcome = v_pt_any ? WP_MISS_PRESENT : WP_TRUE_MISS;
    end

    // prediction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_hit   <= 1'b0;
            pred_way   <= '0;
        end else begin
            pred_valid <= lk_valid;
            pred_hit   <= lk_valid && lk_any;
            pred_way   <= lk_way;
        end
    end

    // outcome register and fill request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_valid  <= 1'b0;
            cls_onehot <= '0;
            fill_req   <= 1'b0;
        end else begin
            cls_valid  <= vl_valid;
            cls_onehot <= vl_valid ? (WP_CLS_W'(1) << outcome) : '0;
            fill_req   <= vl_valid && (outcome != WP_TRUE_HIT);
        end
    end

    // R2
    pred_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid);
    // R3
    ut_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit) && $onehot0(f_ut_hit));
    // R9
    line_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(f_pt_hit) && $onehot0(v_pt_hit));
    // R4
    cls_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> $countones(cls_onehot) == 1);
    // R5
    fill_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (cls_valid && !cls_onehot[0]));
endmodule

// File: tb/test_linear_way_predictor.sv
// Bench: reference model of the set arrays built from the requirements,
// directed corner sequences and seeded random traffic.
module test_linear_way_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, vl_valid = 1'b0, fl_valid = 1'b0;
    logic [27:6] lk_laddr = '0, vl_laddr = '0, fl_laddr = '0;
    logic [23:0] vl_ptag = '0, fl_ptag = '0;
    logic [2:0]  fl_victim = '0;
    logic        pred_valid, pred_hit, cls_valid, fill_req;
    logic [2:0]  pred_way;
    logic [3:0]  cls_onehot;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit          m_vld [64][8];
    logic [7:0]  m_ut  [64][8];
    logic [23:0] m_pt  [64][8];

    always #5 clk = ~clk;

    linear_way_predictor i_linear_way_predictor (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_laddr(lk_laddr),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_way(pred_way),
        .vl_valid(vl_valid), .vl_laddr(vl_laddr), .vl_ptag(vl_ptag),
        .cls_valid(cls_valid), .cls_onehot(cls_onehot), .fill_req(fill_req),
        .fl_valid(fl_valid), .fl_laddr(fl_laddr), .fl_ptag(fl_ptag),
        .fl_victim(fl_victim));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [27:6] mk(input int idx, input logic [7:0] lo, input logic [7:0] hi);
        logic [27:6] a;
        a[11:6]  = idx[5:0];
        a[19:12] = lo;
        a[27:20] = hi;
        return a;
    endfunction

    function automatic logic [7:0] hsh(input logic [27:6] a);
        return a[19:12] ^ a[27:20];
    endfunction

    function automatic int find_ut(input int idx, input logic [7:0] h);
        int r = -1;
        for (int w = 0; w < 8; w++) if (m_vld[idx][w] && m_ut[idx][w] == h) r = w;
        return r;
    endfunction

    function automatic int find_pt(input int idx, input logic [23:0] p);
        int r = -1;
        for (int w = 0; w < 8; w++) if (m_vld[idx][w] && m_pt[idx][w] == p) r = w;
        return r;
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < 64; s++) for (int w = 0; w < 8; w++) m_vld[s][w] = 0;
    endfunction

    // fill rules R6..R9 applied to the model
    function automatic void model_fill(input logic [27:6] a, input logic [23:0] p, input logic [2:0] v);
        int idx = int'(a[11:6]);
        logic [7:0] h = hsh(a);
        int u = find_ut(idx, h);
        int q = find_pt(idx, p);
        if (q >= 0) begin
            m_ut[idx][q] = h;
            if (u >= 0 && u != q) m_vld[idx][u] = 0;
        end else if (u >= 0) begin
            m_pt[idx][u] = p;
        end else begin
            m_vld[idx][v] = 1; m_ut[idx][v] = h; m_pt[idx][v] = p;
        end
    endfunction

    // one cycle: optional fill plus optional lookup+validation of one address
    task automatic step(input bit df, input logic [27:6] fa, input logic [23:0] fp, input logic [2:0] fv,
                        input bit dp, input logic [27:6] pa, input logic [23:0] pp, input string ctx);
        int idx, eu, eq, ecls;
        idx = int'(pa[11:6]);
        eu = find_ut(idx, hsh(pa));
        eq = find_pt(idx, pp);
        if (eu >= 0) ecls = (m_pt[idx][eu] == pp) ? 0 : 1;
        else         ecls = (eq >= 0) ? 2 : 3;
        fl_valid = df; fl_laddr = fa; fl_ptag = fp; fl_victim = fv;
        lk_valid = dp; lk_laddr = pa;
        vl_valid = dp; vl_laddr = pa; vl_ptag = pp;
        @(negedge clk);
        fl_valid = 0; lk_valid = 0; vl_valid = 0;
        if (dp) begin
            chk(pred_valid === 1'b1, {"R2 pred_valid ", ctx}, pred_valid, 1);
            chk(pred_hit === (eu >= 0), {"R2 pred_hit ", ctx}, pred_hit, eu >= 0);
            if (eu >= 0) chk(pred_way === 3'(eu), {"R3 pred_way ", ctx}, pred_way, eu);
            chk(cls_valid === 1'b1 && cls_onehot === 4'(1 << ecls), {"R4 class ", ctx}, cls_onehot, 1 << ecls);
            chk(fill_req === (ecls != 0), {"R5 fill_req ", ctx}, fill_req, ecls != 0);
        end else begin
            chk(pred_valid === 1'b0 && cls_valid === 1'b0, {"R2 idle strobes ", ctx}, {pred_valid, cls_valid}, 0);
        end
        if (df) model_fill(fa, fp, fv);
    endtask

    task automatic probe(input logic [27:6] a, input logic [23:0] p, input string ctx);
        step(0, '0, '0, '0, 1, a, p, ctx);
    endtask

    task automatic fill(input logic [27:6] a, input logic [23:0] p, input logic [2:0] v, input string ctx);
        step(1, a, p, v, 0, '0, '0, ctx);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] lo_pool [4];
        logic [7:0] hi_pool [2];
        int sets [4];
        lo_pool = '{8'h00, 8'h01, 8'h5A, 8'hA5};
        hi_pool = '{8'h00, 8'h5B};
        sets = '{3, 17, 40, 63};
        void'($urandom(32'h5EED));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(pred_valid === 1'b0 && cls_valid === 1'b0 && fill_req === 1'b0, "R10 reset strobes",
            {pred_valid, cls_valid, fill_req}, 0);
        probe(mk(3, 8'h11, 8'h00), 24'hA, "R10 empty after reset");

        fill(mk(3, 8'h11, 8'h00), 24'hA, 3'd5, "R6");
        probe(mk(3, 8'h11, 8'h00), 24'hA, "R6 victim written");
        fill(mk(3, 8'h10, 8'h01), 24'hB, 3'd2, "R7");
        probe(mk(3, 8'h10, 8'h01), 24'hB, "R7 same-hash way reused");
        probe(mk(3, 8'h11, 8'h00), 24'hA, "R7 old line gone");
        chk(pred_way === 3'd5, "R7 victim ignored", pred_way, 5);
        fill(mk(3, 8'h22, 8'h00), 24'hC, 3'd1, "R6");
        fill(mk(3, 8'h33, 8'h00), 24'hC, 3'd6, "R8");
        probe(mk(3, 8'h33, 8'h00), 24'hC, "R8 tag rewritten");
        chk(pred_way === 3'd1, "R8 line stays in place", pred_way, 1);
        probe(mk(3, 8'h22, 8'h00), 24'hC, "R8 old hash gone");
        fill(mk(3, 8'h11, 8'h00), 24'hC, 3'd0, "R9");
        probe(mk(3, 8'h10, 8'h01), 24'hB, "R9 hash moved to line way");
        chk(pred_way === 3'd1, "R9 line way kept", pred_way, 1);
        probe(mk(3, 8'h44, 8'h00), 24'hB, "R9 other way invalidated");
        probe(mk(4, 8'h11, 8'h00), 24'hC, "R1 other set untouched");
        step(1, mk(3, 8'h55, 8'h00), 24'hD, 3'd3, 1, mk(3, 8'h55, 8'h00), 24'hD, "R11 same cycle");
        probe(mk(3, 8'h55, 8'h00), 24'hD, "R11 visible next cycle");

        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; model_clear();
        probe(mk(3, 8'h55, 8'h00), 24'hD, "R10 reset clears valid");

        for (int n = 0; n < 3000; n++) begin
            bit df, dp;
            logic [27:6] fa, pa;
            df = ($urandom % 2) == 0;
            dp = ($urandom % 5) != 0;
            fa = mk(sets[$urandom % 4], lo_pool[$urandom % 4], hi_pool[$urandom % 2]);
            pa = mk(sets[$urandom % 4], lo_pool[$urandom % 4], hi_pool[$urandom % 2]);
            step(df, fa, 24'h100000 + 24'($urandom % 6), 3'($urandom % 8),
                 dp, pa, 24'h100000 + 24'($urandom % 6), "random R3 R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule